// File: doc/BRIEF.md
# Two-Port Synchronous Block Memory

This block is a memory with two ports. One port only writes and the other only reads. Each port has its own clock, enable and address, and both ports reach the same storage array. The data width is a parameter from 1 to 72 bits, and a capacity-class parameter selects a small (18 Kb) or large (36 Kb) array. The depth, the address width and the number of byte-enable bits all follow from those two parameters. The read side can add an optional output register, which adds one cycle of latency and has its own clock enable.

The read port has a synchronous reset that forces the output to a programmable value. Before the first read or reset, the output shows a second programmable power-up value. A write-mode parameter sets what a read returns when it hits the address being written in the same cycle:
- Write-first returns the new word.
- Read-first returns the stored word.

Top module: `sdp_ram`

## Requirements
- R1: The depth for the large class is 512 words for widths 37–72, 1024 for 19–36, 2048 for 10–18, 4096 for 5–9, 8192 for 3–4, 16384 for width 2 and 32768 for width 1. The small class has half those depths. The address width is log2 of the depth, and every word from 0 to depth−1, including the top address, is individually stored.
- R2: A bit is written only when `wr_en` is high and its byte-enable bit is high. Byte-enable bit i covers data bits 9i..9i+8 when the width is a multiple of 9, and bits 8i..8i+7 otherwise; the top enable also covers any leftover upper bits. The enable is 8 bits wide for widths 37–72, 4 for 19–36, 2 for 10–18 and 1 for widths of 9 or less.
- R3: With no output register, the word at `rd_addr` appears on `rd_data` one read-clock edge after it is sampled with `rd_en` high. With the output register, it appears two edges later when `out_ce` is high.
- R4: While `rd_en` is low, the first read stage keeps its value. Without the output register, `rd_data` therefore holds.
- R5: A high `rd_rst` at a read-clock edge loads the reset value into the final output stage. Reset takes priority over `rd_en` and `out_ce`, and it never alters the stored words.
- R6: Before any reset or read, `rd_data` shows the power-up value.
- R7: In write-first mode, a read and a write to the same address at the same edge return the newly merged word.
- R8: In read-first mode, a read and a write to the same address at the same edge return the word stored before the write.
- R9: With the output register, `out_ce` low holds `rd_data`. Without the output register, `out_ce` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_en | input | 1 | Write enable |
| wr_be | input | BE_W | Byte-lane write enables |
| wr_addr | input | AW | Write address |
| wr_data | input | DATA_W | Write data |
| rd_clk | input | 1 | Read clock |
| rd_en | input | 1 | Read enable for the first read stage |
| rd_rst | input | 1 | Synchronous reset of the final output stage |
| out_ce | input | 1 | Clock enable of the optional output register |
| rd_addr | input | AW | Read address |
| rd_data | output | DATA_W | Read data |

## Verification
Two functions can land on the same edge:
- **Read-write collision:** a write and a read to the same address. The bench drives both ports from one clock and issues such collisions with full and partial byte enables.
- **Reset against enables:** a reset and a read or output-enable pulse.

Two instances, one write-first without the output register and one read-first with it, run from the same stimulus. A behavioural model predicts each collision outcome from the write-mode rule and each reset outcome from reset priority. Every edge is compared against that model.

// File: rtl/sdp_ram.sv
module sdp_ram #(
  parameter int          DATA_W      = 36,
  parameter bit          BIG         = 1'b1,
  parameter bit          OUT_REG     = 1'b0,
  parameter logic [71:0] RST_VAL     = '0,
  parameter logic [71:0] INIT_VAL    = '0,
  parameter bit          WRITE_FIRST = 1'b1,
  localparam int BASE  = DATA_W > 36 ? 512 : DATA_W > 18 ? 1024 : DATA_W > 9 ? 2048 :
                         DATA_W > 4 ? 4096 : DATA_W > 2 ? 8192 : DATA_W == 2 ? 16384 : 32768,
  localparam int DEPTH = BIG ? BASE : BASE / 2,
  localparam int AW    = $clog2(DEPTH),
  localparam int BE_W  = DATA_W > 36 ? 8 : DATA_W > 18 ? 4 : DATA_W > 9 ? 2 : 1
) (
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [BE_W-1:0]   wr_be,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_en,
  input  logic              rd_rst,
  input  logic              out_ce,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int LANE_W = BE_W == 1 ? DATA_W : (DATA_W % 9 == 0 ? 9 : 8);
  localparam logic [DATA_W-1:0] RV = RST_VAL[DATA_W-1:0];
  localparam logic [DATA_W-1:0] IV = INIT_VAL[DATA_W-1:0];

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] wmask;
  logic [DATA_W-1:0] q1 = IV;

  for (genvar b = 0; b < DATA_W; b++) begin : g_mask
    localparam int RAW = b / LANE_W;
    localparam int LN  = RAW < BE_W ? RAW : BE_W - 1;
    assign wmask[b] = wr_be[LN];
  end

  always_ff @(posedge wr_clk)
    if (wr_en) mem[wr_addr] <= (mem[wr_addr] & ~wmask) | (wr_data & wmask);

  wire               hit     = WRITE_FIRST && wr_en && (wr_addr == rd_addr);
  wire [DATA_W-1:0]  stored  = mem[rd_addr];
  wire [DATA_W-1:0]  rd_word = hit ? ((stored & ~wmask) | (wr_data & wmask)) : stored;

  if (OUT_REG) begin : g_reg
    logic [DATA_W-1:0] q2 = IV;
    always_ff @(posedge rd_clk)
      if (rd_en) q1 <= rd_word;
    always_ff @(posedge rd_clk)
      if (rd_rst)      q2 <= RV;
      else if (out_ce) q2 <= q1;
    assign rd_data = q2;
  end else begin : g_noreg
    wire unused_ce = out_ce;
    always_ff @(posedge rd_clk)
      if (rd_rst)     q1 <= RV;
      else if (rd_en) q1 <= rd_word;
    assign rd_data = q1;
  end
endmodule

// File: rtl/sdp_ram_chk.sv
module sdp_ram_chk #(
  parameter int          DATA_W      = 36,
  parameter bit          OUT_REG     = 1'b0,
  parameter bit          WRITE_FIRST = 1'b1,
  parameter logic [71:0] RST_VAL     = '0,
  parameter int          AW          = 10,
  parameter int          BE_W        = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic              out_ce,
  input logic              wr_en,
  input logic [BE_W-1:0]   wr_be,
  input logic [AW-1:0]     wr_addr,
  input logic [AW-1:0]     rd_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] stage1,
  input logic [DATA_W-1:0] dout
);
  AST_RST_LOAD: assert property (@(posedge clk) rst |=> dout == RST_VAL[DATA_W-1:0]); // R5

  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(stage1)); // R4

  if (OUT_REG) begin : g_reg
    AST_CE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !out_ce |=> $stable(dout)); // R9
    AST_REG_CHAIN: assert property (@(posedge clk) disable iff (rst)
      out_ce |=> dout == $past(stage1)); // R3
  end else begin : g_noreg
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !rd_en |=> $stable(dout)); // R4
  end

  if (WRITE_FIRST) begin : g_wf
    AST_WF_BYPASS: assert property (@(posedge clk) disable iff (rst)
      wr_en && rd_en && (wr_addr == rd_addr) && (&wr_be) |=> stage1 == $past(wr_data)); // R7
  end
endmodule

bind sdp_ram sdp_ram_chk #(
  .DATA_W(DATA_W), .OUT_REG(OUT_REG), .WRITE_FIRST(WRITE_FIRST),
  .RST_VAL(RST_VAL), .AW(AW), .BE_W(BE_W)
) u_chk (
  .clk(rd_clk), .rst(rd_rst), .rd_en(rd_en), .out_ce(out_ce), .wr_en(wr_en),
  .wr_be(wr_be), .wr_addr(wr_addr), .rd_addr(rd_addr), .wr_data(wr_data),
  .stage1(q1), .dout(rd_data)
);

// File: tb/sdp_ram_tb.sv
module sdp_ram_tb;
  localparam int W = 36;
  localparam int A = 10;
  localparam int B = 4;
  localparam logic [71:0] RV = 72'h5A5A5A5A5;
  localparam logic [71:0] IV = 72'h123456789;

  logic         clk = 1'b0;
  logic         wr_en = 1'b0, rd_en = 1'b0, rst = 1'b0, ce = 1'b0;
  logic [B-1:0] be = '0;
  logic [A-1:0] wa = '0, ra = '0;
  logic [W-1:0] wd = '0;
  logic [W-1:0] doa, dob;

  int    vectors = 0, errors = 0;
  bit    done = 1'b0;
  string tag = "R6";

  always #5 clk = ~clk;

  sdp_ram #(.DATA_W(W), .BIG(1'b1), .OUT_REG(1'b0), .RST_VAL(RV), .INIT_VAL(IV), .WRITE_FIRST(1'b1)) u_dut (
    .wr_clk(clk), .wr_en(wr_en), .wr_be(be), .wr_addr(wa), .wr_data(wd),
    .rd_clk(clk), .rd_en(rd_en), .rd_rst(rst), .out_ce(ce), .rd_addr(ra), .rd_data(doa));

  sdp_ram #(.DATA_W(W), .BIG(1'b1), .OUT_REG(1'b1), .RST_VAL(RV), .INIT_VAL(IV), .WRITE_FIRST(1'b0)) u_dut_reg (
    .wr_clk(clk), .wr_en(wr_en), .wr_be(be), .wr_addr(wa), .wr_data(wd),
    .rd_clk(clk), .rd_en(rd_en), .rd_rst(rst), .out_ce(ce), .rd_addr(ra), .rd_data(dob));

  logic [W-1:0] mm [int];
  logic [W-1:0] ea = IV[W-1:0], eb1 = IV[W-1:0], eb2 = IV[W-1:0];

  function automatic logic [W-1:0] peek(int a);
    return mm.exists(a) ? mm[a] : '0;
  endfunction

  always @(posedge clk) begin
    logic [W-1:0] mask, oldr, neww;
    for (int l = 0; l < B; l++) mask[9*l +: 9] = {9{be[l]}};
    oldr = peek(int'(ra));
    neww = (peek(int'(wa)) & ~mask) | (wd & mask);
    if (rst) ea = RV[W-1:0];
    else if (rd_en) ea = (wr_en && wa == ra) ? neww : oldr;
    if (rst) eb2 = RV[W-1:0];
    else if (ce) eb2 = eb1;
    if (rd_en) eb1 = oldr;
    if (wr_en) mm[int'(wa)] = neww;
  end

  task automatic step();
    @(posedge clk);
    #1;
    vectors++;
    if (doa !== ea) begin
      errors++;
      $display("FAIL %s direct port: got %h expected %h", tag, doa, ea);
    end
    if (dob !== eb2) begin
      errors++;
      $display("FAIL %s registered port: got %h expected %h", tag, dob, eb2);
    end
  endtask

  function automatic logic [W-1:0] pat(int i);
    return W'(i * 36'h10F3) ^ 36'h9AB000000;
  endfunction

  initial begin
    // R6: power-up value with no read and no reset
    ce = 1'b1;
    repeat (3) step();
    // R5: reset loads the reset value
    tag = "R5"; rst = 1'b1; step(); rst = 1'b0; step();
    // R1: fill low addresses and the top address (depth 1024 for width 36)
    tag = "R1"; wr_en = 1'b1; be = '1;
    for (int i = 0; i < 16; i++) begin wa = A'(i); wd = pat(i); step(); end
    wa = A'(1023); wd = 36'hFEDCBA987; step();
    wr_en = 1'b0;
    // R3: sequential reads through both latencies
    tag = "R3"; rd_en = 1'b1;
    for (int i = 0; i < 16; i++) begin ra = A'(i); step(); end
    tag = "R1"; ra = A'(1023); step(); ra = A'(0); step(); step();
    // R2: partial lane writes and a disabled write
    tag = "R2"; rd_en = 1'b0; wr_en = 1'b1; wd = 36'hFFFFFFFFF;
    wa = A'(2); be = 4'b0001; step();
    wa = A'(3); be = 4'b1010; step();
    wa = A'(4); be = 4'b0100; step();
    wa = A'(5); be = 4'b0000; step();
    wr_en = 1'b0; wa = A'(6); be = 4'b1111; step();
    rd_en = 1'b1;
    for (int i = 2; i < 7; i++) begin ra = A'(i); step(); end
    step(); step();
    // R4: read enable low holds the first stage
    tag = "R4"; rd_en = 1'b0;
    for (int i = 8; i < 12; i++) begin ra = A'(i); step(); end
    // R9: output clock enable low freezes the registered port only
    tag = "R9"; rd_en = 1'b1; ce = 1'b0;
    for (int i = 8; i < 12; i++) begin ra = A'(i); step(); end
    ce = 1'b1; step(); step();
    // R7 and R8: same-address collisions
    tag = "R7"; wr_en = 1'b1; be = '1;
    wa = A'(9); ra = A'(9); wd = 36'h0AAAAAAAA; step();
    tag = "R8"; wa = A'(10); ra = A'(10); wd = 36'h055555555; be = 4'b0110; step();
    tag = "R7"; wa = A'(11); ra = A'(11); wd = 36'h777777777; be = 4'b1001; step();
    wr_en = 1'b0; tag = "R8";
    for (int i = 9; i < 12; i++) begin ra = A'(i); step(); end
    step(); step();
    // R5: reset beats read and clock enables; storage survives
    tag = "R5"; rst = 1'b1; ra = A'(7); step();
    ce = 1'b0; step(); rst = 1'b0; ce = 1'b1;
    for (int i = 0; i < 8; i++) begin ra = A'(i); step(); end
    step(); step();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule